// File: doc/BRIEF.md
# Isolated Gate-State Link

This block carries one on/off gate command from a controller domain to a power-stage domain over a one-bit serial line that stands in for an isolation barrier. The transmitter half watches `cmd_on`. It launches a three-bit frame as soon as the command changes. It also relaunches the current state at a fixed refresh interval, so a frame that is lost or damaged on the line is replaced soon after.

The receiver half decodes frames from `rx_line` and drives `gate_on` from every frame that passes its check. A second timer counts the cycles since the last good frame. If that count runs out, the receiver forces the gate off and drops `link_ok`. The link is declared healthy again only after a run of consecutive good frames. In the system, `tx_line` is routed through the barrier model to `rx_line`. In the bench, that path passes through a fault injector that can zero or flip bits.

Both halves share one clock. The command and status pins are plain levels with no handshake.

Top module: `gate_link`

## Requirements
- R1: While `rst_n` is low, and after reset until a frame carrying "on" is accepted, `gate_on` is 0, `link_ok` is 1 and `tx_line` is 0 while held in reset.
- R2: A frame is three consecutive line bits: a start bit of 1, the data bit (1 = gate on), then the complement of the data bit. Between frames the line is 0.
- R3: A frame is launched on the first clock edge at which the command differs from the last value sent and the line is idle or carrying a check bit. The data bit is the command sampled at that edge. `gate_on` takes the frame's value on the third edge after the launch.
- R4: With a steady command, frames are relaunched every `REFRESH_CYC` edges, and the first frame goes out on the first edge after reset.
- R5: An off command has priority. If the command falls while an "on" frame is still before its check bit, the transmitter sends an invalid check bit (equal to the data bit) and launches an "off" frame right after. `gate_on` never rises from that aborted frame.
- R6: A frame whose check bit equals its data bit is discarded with no effect on `gate_on`. The state it should have carried arrives with the next refresh frame, `REFRESH_CYC` edges after the damaged launch.
- R7: If no valid frame completes for `WD_PERIODS*REFRESH_CYC` edges while the link is up, `link_ok` and `gate_on` both go to 0 on that edge.
- R8: While the link is down, `gate_on` is held at 0. On the `REARM_FRAMES`-th consecutive valid frame, `link_ok` returns to 1 and `gate_on` takes that frame's value. An invalid frame restarts the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both halves |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_on | input | 1 | Requested gate state from the control side |
| tx_line | output | 1 | Serial line driven by the transmitter half |
| rx_line | input | 1 | Serial line sampled by the receiver half after the barrier |
| gate_on | output | 1 | Decoded gate state, forced low on link failure |
| link_ok | output | 1 | High while valid frames keep arriving |

## Verification
Every result is tied to a launch edge. The bench takes each launch edge from `tx_line` as it happens, treating a 1 seen outside a frame as a start bit. From that edge it computes the edge at which `gate_on` must change: the launch edge (or three edges after a frame already on the line) plus three. A timeout falls `WD_PERIODS*REFRESH_CYC` edges after the last good check bit. Recovery falls three edges after the `REARM_FRAMES`-th good launch. All of these are computed arithmetically and compared with the edge count at which the port actually moved. The change-to-output latency is swept over every offset inside one refresh period, in both directions. Inputs are driven and outputs sampled on the falling edge, so each comparison names one exact rising edge.

// File: rtl/gate_link_pkg.sv
package gate_link_pkg;
  // Bit currently on the line (transmitter) or bit expected next (receiver).
  typedef enum logic [1:0] {PH_IDLE, PH_START, PH_DATA, PH_CHECK} phase_t;
endpackage

// File: rtl/gate_link_tx.sv
module gate_link_tx
  import gate_link_pkg::*;
#(
  parameter int REFRESH_CYC = 62
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_on,
  output logic tx_line
);
  localparam int RW = (REFRESH_CYC > 2) ? $clog2(REFRESH_CYC) : 2;
  localparam logic [RW-1:0] AGE_DUE = RW'(REFRESH_CYC - 1);

  phase_t         ph;
  logic           data_q;   // data bit of the frame on the line
  logic           sent_q;   // last state handed to a frame
  logic [RW-1:0]  age;      // edges since the last launch

  logic slot_free, refresh_due, changed, launch, abort_on;

  always_comb begin
    slot_free   = (ph == PH_IDLE) || (ph == PH_CHECK);
    refresh_due = (age == AGE_DUE);
    changed     = (cmd_on != sent_q);
    launch      = slot_free && (changed || refresh_due);
    abort_on    = (ph == PH_DATA) && data_q && !cmd_on;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph      <= PH_IDLE;
      tx_line <= 1'b0;
      data_q  <= 1'b0;
      sent_q  <= 1'b0;
      age     <= AGE_DUE;
    end else if (launch) begin
      ph      <= PH_START;
      tx_line <= 1'b1;
      data_q  <= cmd_on;
      sent_q  <= cmd_on;
      age     <= '0;
    end else begin
      if (!refresh_due) age <= age + 1'b1;
      case (ph)
        PH_START: begin
          tx_line <= data_q;
          ph      <= PH_DATA;
        end
        PH_DATA: begin
          // a falling command spoils the check bit of an in-flight "on"
          tx_line <= abort_on ? data_q : ~data_q;
          ph      <= PH_CHECK;
        end
        default: begin
          tx_line <= 1'b0;
          ph      <= PH_IDLE;
        end
      endcase
    end
  end

  p_change_launch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_free && changed) |=> (tx_line && ph == PH_START && data_q == $past(cmd_on)));

  p_refresh_launch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_free && refresh_due) |=> (tx_line && age == '0));

  p_off_priority_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_DATA && data_q && !cmd_on) |=> (tx_line && ph == PH_CHECK && sent_q));

  p_start_then_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_START) |=> (tx_line == $past(data_q)));
endmodule

// File: rtl/gate_link_rx.sv
module gate_link_rx
  import gate_link_pkg::*;
#(
  parameter int REFRESH_CYC  = 62,
  parameter int WD_PERIODS   = 4,
  parameter int REARM_FRAMES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_line,
  output logic gate_on,
  output logic link_ok
);
  localparam int TIMEOUT = WD_PERIODS * REFRESH_CYC;
  localparam int WW = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 2;
  localparam int GW = (REARM_FRAMES > 2) ? $clog2(REARM_FRAMES) : 1;
  localparam logic [WW-1:0] WD_LAST = WW'(TIMEOUT - 1);
  localparam logic [GW-1:0] GOOD_LAST = GW'(REARM_FRAMES - 1);

  phase_t         ph;
  logic           d_q;
  logic [WW-1:0]  wd_cnt;
  logic [GW-1:0]  good_cnt;

  logic frame_ok, frame_bad, expired;

  always_comb begin
    frame_ok  = (ph == PH_CHECK) && (rx_line != d_q);
    frame_bad = (ph == PH_CHECK) && (rx_line == d_q);
    expired   = link_ok && !frame_ok && (wd_cnt == WD_LAST);
  end

  // frame deserialiser
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph  <= PH_IDLE;
      d_q <= 1'b0;
    end else begin
      case (ph)
        PH_IDLE:  if (rx_line) ph <= PH_DATA;
        PH_DATA:  begin d_q <= rx_line; ph <= PH_CHECK; end
        default:  ph <= PH_IDLE;
      endcase
    end
  end

  // loss-of-link timer
  always_ff @(posedge clk) begin
    if (!rst_n)             wd_cnt <= '0;
    else if (frame_ok)      wd_cnt <= '0;
    else if (wd_cnt != WD_LAST) wd_cnt <= wd_cnt + 1'b1;
  end

  // gate state and link health
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gate_on  <= 1'b0;
      link_ok  <= 1'b1;
      good_cnt <= '0;
    end else if (link_ok) begin
      if (frame_ok) gate_on <= d_q;
      else if (expired) begin
        gate_on  <= 1'b0;
        link_ok  <= 1'b0;
        good_cnt <= '0;
      end
    end else if (frame_ok) begin
      if (good_cnt == GOOD_LAST) begin
        link_ok  <= 1'b1;
        gate_on  <= d_q;
        good_cnt <= '0;
      end else begin
        good_cnt <= good_cnt + 1'b1;
      end
    end else if (frame_bad) begin
      good_cnt <= '0;
    end
  end

  p_gate_needs_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_on) |-> $past(ph == PH_CHECK && rx_line != d_q));

  p_timeout_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(link_ok) |-> ($past(wd_cnt) == WD_LAST && !gate_on));

  p_down_holds_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !link_ok |-> !gate_on);

  p_rearm_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_ok) |-> ($past(good_cnt) == GOOD_LAST && $past(frame_ok)));
endmodule

// File: rtl/gate_link.sv
module gate_link #(
  parameter int REFRESH_CYC  = 62,
  parameter int WD_PERIODS   = 4,
  parameter int REARM_FRAMES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_on,
  output logic tx_line,
  input  logic rx_line,
  output logic gate_on,
  output logic link_ok
);
  gate_link_tx #(.REFRESH_CYC(REFRESH_CYC)) u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmd_on  (cmd_on),
    .tx_line (tx_line)
  );

  gate_link_rx #(
    .REFRESH_CYC  (REFRESH_CYC),
    .WD_PERIODS   (WD_PERIODS),
    .REARM_FRAMES (REARM_FRAMES)
  ) u_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .rx_line (rx_line),
    .gate_on (gate_on),
    .link_ok (link_ok)
  );

  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |=> (!tx_line && !gate_on && link_ok));
endmodule

// File: tb/gate_link_test.sv
module gate_link_test;
  localparam int RC = 8;
  localparam int WP = 4;
  localparam int RA = 3;
  localparam int TO = WP * RC;

  logic clk = 1'b0;
  logic rst_n, cmd_on, flip, block;
  logic tx_line, rx_line, gate_on, link_ok;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc = 0;
  int last_launch = -100;
  int prev_launch = -100;
  int trk = 0;
  bit done = 0;

  always #4 clk = ~clk;

  assign rx_line = block ? 1'b0 : (tx_line ^ flip);

  gate_link #(.REFRESH_CYC(RC), .WD_PERIODS(WP), .REARM_FRAMES(RA)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_on(cmd_on), .tx_line(tx_line),
    .rx_line(rx_line), .gate_on(gate_on), .link_ok(link_ok)
  );

  // launch tracker: a 1 outside a frame is a start bit launched one edge ago
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) trk <= 0;
    else if (trk == 0 && tx_line) begin
      trk <= 2;
      prev_launch <= last_launch;
      last_launch <= cyc;
    end else if (trk > 0) trk <= trk - 1;
  end

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wait_launch_after(input int n);
    for (int g = 0; g < 200 && last_launch <= n; g++) step();
  endtask

  task automatic wait_idle();
    int g = 0;
    do begin step(); g++; end
    while (!(tx_line == 1'b0 && cyc >= last_launch + 3) && g < 200);
  endtask

  task automatic wait_gate(input logic v, output int m);
    for (int g = 0; g < 300 && gate_on != v; g++) step();
    m = (gate_on == v) ? cyc : -1;
  endtask

  task automatic wait_link(input logic v, output int m, output int hi_while_down);
    hi_while_down = 0;
    for (int g = 0; g < 300 && link_ok != v; g++) begin
      if (!link_ok && gate_on) hi_while_down++;
      step();
    end
    m = (link_ok == v) ? cyc : -1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int e, l, m, hi, u;
    rst_n = 1'b0; cmd_on = 1'b0; flip = 1'b0; block = 1'b0;
    repeat (3) step();
    check("R1 gate_on in reset", gate_on, 0);
    check("R1 link_ok in reset", link_ok, 1);
    check("R1 tx_line in reset", tx_line, 0);
    rst_n = 1'b1;
    step();
    check("R4 first frame on first edge", last_launch == cyc - 1 || tx_line, 1);
    repeat (6) step();
    check("R1 gate stays off after reset", gate_on, 0);

    // R2 frame shape for "off" then R4 spacing
    wait_launch_after(cyc);
    check("R2 data bit off", tx_line, 0);
    step();
    check("R2 check bit off", tx_line, 1);
    step();
    check("R2 idle after frame", tx_line, 0);
    wait_launch_after(last_launch);
    check("R4 refresh spacing", last_launch - prev_launch, RC);

    // R3 sweep of change offset inside one refresh period, both directions
    for (int d = 0; d < RC + 3; d++) begin
      wait_launch_after(cyc);
      repeat (d) step();
      l = (tx_line && cyc >= last_launch + 3) ? cyc : last_launch;
      e = cyc + 1;
      cmd_on = ~cmd_on;
      wait_gate(cmd_on, m);
      check($sformatf("R3 latency offset %0d dir %0d", d, cmd_on), m,
            ((e >= l + 3) ? e : l + 3) + 3);
    end
    check("R3 link stays up", link_ok, 1);

    // R2 frame shape for "on" (command is on after the odd sweep)
    wait_launch_after(cyc);
    check("R2 data bit on", tx_line, 1);
    step();
    check("R2 check bit on", tx_line, 0);

    // R6 damaged "on" frame: data bit flipped
    cmd_on = 1'b0;
    wait_gate(1'b0, m);
    wait_idle();
    e = cyc + 1;
    cmd_on = 1'b1;
    step(); step();
    flip = 1'b1;
    step();
    flip = 1'b0;
    wait_gate(1'b1, m);
    check("R6 on delayed one refresh", m, e + RC + 3);

    // R6 damaged "off" frame: check bit flipped
    wait_idle();
    e = cyc + 1;
    cmd_on = 1'b0;
    step(); step(); step();
    flip = 1'b1;
    step();
    flip = 1'b0;
    wait_gate(1'b0, m);
    check("R6 off delayed one refresh", m, e + RC + 3);

    // R5 off priority: a short on pulse must never reach the gate
    for (int h = 1; h <= 2; h++) begin
      wait_idle();
      cmd_on = 1'b1;
      repeat (h) step();
      cmd_on = 1'b0;
      hi = 0;
      for (int k = 0; k < 10; k++) begin
        if (gate_on) hi++;
        step();
      end
      check($sformatf("R5 aborted on pulse %0d", h), hi, 0);
    end

    // R7 loss of link
    cmd_on = 1'b1;
    wait_gate(1'b1, m);
    wait_launch_after(cyc);
    l = last_launch;
    step(); step();
    block = 1'b1;
    wait_link(1'b0, m, hi);
    check("R7 timeout edge", m, l + 3 + TO);
    check("R7 gate forced off", gate_on, 0);

    // R8 recovery after REARM valid frames
    repeat (5) step();
    wait_idle();
    u = cyc;
    block = 1'b0;
    wait_launch_after(u);
    l = last_launch;
    wait_link(1'b1, m, hi);
    check("R8 rearm edge", m, l + (RA - 1) * RC + 3);
    check("R8 gate off while down", hi, 0);
    check("R8 gate follows rearm frame", gate_on, 1);

    // R8 an invalid frame restarts the count
    wait_launch_after(cyc);
    step(); step();
    block = 1'b1;
    wait_link(1'b0, m, hi);
    wait_idle();
    u = cyc;
    block = 1'b0;
    wait_launch_after(u);
    l = last_launch;
    wait_launch_after(l);
    flip = 1'b1;
    step();
    flip = 1'b0;
    wait_link(1'b1, m, hi);
    check("R8 restart after bad frame", m, l + (RA + 1) * RC + 3);
    check("R8 gate off during second outage", hi, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule